// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is a preloadable up-counter with three ways of advancing. It can tick on a fixed division of the system clock. It can count chosen edges of an external pin. It can measure how long that pin stays at a chosen level. When the counter passes its all-ones value, it does three things. It reloads itself from a preload register and keeps counting. It sets a sticky interrupt flag, which drives the interrupt output only when an enable bit allows it. In edge-counting mode it can also raise a wake-up request while the chip is powered down.

Software reaches the block through a small register port. There are four word addresses, a write strobe and a combinational read bus. The external pin passes through a multi-flop synchronizer before any edge or level is taken from it. The power-down input stops the internally clocked modes. It does not stop edge counting.

Top module: `tmr_evt_cnt`

## Requirements
- R1: After reset, every register reads zero (mode, run, edge select, preload, count, flag, interrupt enable), and the `irq` and `wake` outputs are 0.
- R2: Register map. Address 0 is control: bits 7:6 are the mode (00 stopped, 01 pin-edge count, 10 divided-clock timer, 11 pulse width), bit 4 is run and bit 3 is edge/level select. Its other bits read 0. Writing address 1 sets the preload, and reading it returns the count. Address 2 holds the flag at bit 0 and the interrupt enable at bit 1. Reading address 3 returns the preload.
- R3: A preload write while run is 0 also loads the counter. While run is 1 it changes only the preload.
- R4: In timer mode with run set, the count rises by one every 4 clock cycles. The first step lands on the 4th rising clock edge after the edge that sets run.
- R5: With run at 0, or with mode 00, the count never changes except by a preload write.
- R6: An increment from all-ones loads the preload value into the counter and sets the flag.
- R7: `irq` equals flag AND enable. The flag stays set until a write to address 2 with bit 0 at 0. A write with bit 0 at 1 leaves the flag as it is.
- R8: In pin-edge mode, edge select 0 counts rising pin edges and 1 counts falling pin edges. The count updates on the 3rd rising clock edge after the pin changes.
- R9: In pulse-width mode the count advances on the divided clock only while the pin sits at the active level (high when bit 3 is 0, low when it is 1). When that level ends, the hardware clears run.
- R10: While `pwr_down` is 1, timer and pulse-width counting freeze and pin-edge counting continues. Timer counting resumes when `pwr_down` returns to 0.
- R11: An overflow in pin-edge mode while `pwr_down` is 1 sets `wake`. `wake` stays 1 until `pwr_down` is 0 at a clock edge.
- R12: If an overflow and a flag-clearing write fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| tmr_pin | input | 1 | External count/measure pin (asynchronous) |
| pwr_down | input | 1 | Power-down indication |
| irq | output | 1 | Interrupt request (flag gated by enable) |
| wake | output | 1 | Wake-up request from pin-edge overflow in power-down |

## Verification
Two functions can land on the same edge: the hardware setting the flag on an overflow, and software clearing that flag with a write to address 2. The bench preloads all-ones in pin-edge mode and raises the pin. It then times the clearing write so that its strobe covers exactly the third clock edge after the pin change, which is the edge where the overflow is known to happen. The outcome counts as correct only if the flag reads back set and the counter shows the reloaded value. A following lone clear must still work.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      MODE_OFF = 2'b00,
      MODE_EVT = 2'b01,
      MODE_TMR = 2'b10,
      MODE_PW  = 2'b11
   } tmr_mode_e;

   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd1;
   localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
   localparam logic [ADDR_W-1:0] ADDR_PRE  = 2'd3;

   localparam int MODE_HI  = 7;
   localparam int MODE_LO  = 6;
   localparam int RUN_BIT  = 4;
   localparam int EDGE_BIT = 3;
   localparam int FLAG_BIT = 0;
   localparam int IEN_BIT  = 1;

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign level_o = sync_q[STAGES-1];
   assign rise_o  = level_o & ~prev_q;
   assign fall_o  = ~level_o & prev_q;

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic en_i,
   output logic tick_o
);

   localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);
   localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("tmr_prescaler: DIV must be at least 2");
      end
   endgenerate

   logic [PW-1:0] phase_q;

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       phase_q <= '0;
            else if (clear_i) phase_q <= '0;
            else if (en_i)    phase_q <= phase_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       phase_q <= '0;
            else if (clear_i) phase_q <= '0;
            else if (en_i)    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
         end
      end
   endgenerate

   assign tick_o = en_i & ~clear_i & (phase_q == LAST);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         inc_i,
   input  logic [W-1:0] reload_val_i,
   output logic [W-1:0] cnt_o,
   output logic         ovf_o
);

   logic [W-1:0] cnt_q;

   assign ovf_o = inc_i & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (ovf_o)  cnt_q <= reload_val_i;
      else if (inc_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/tmr_evt_cnt.sv
module tmr_evt_cnt
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int BUS_W       = 8,
   parameter int PRESC_DIV   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   input  logic              tmr_pin,
   input  logic              pwr_down,
   output logic              irq,
   output logic              wake
);

   generate
      if (BUS_W < 8) begin : g_bad_bus
         $error("tmr_evt_cnt: BUS_W must be at least 8");
      end
      if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
         $error("tmr_evt_cnt: CNT_W must lie in 2..BUS_W");
      end
   endgenerate

   tmr_mode_e        mode_q;
   logic             run_q;
   logic             edge_q;
   logic [CNT_W-1:0] pre_q;
   logic             flag_q;
   logic             ien_q;
   logic             wake_q;

   logic wr_ctrl, wr_pre, wr_stat;
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
   assign wr_pre  = reg_wr && (reg_addr == ADDR_CNT);
   assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);

   logic pin_lvl, pin_rise, pin_fall;

   tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (tmr_pin),
      .level_o (pin_lvl),
      .rise_o  (pin_rise),
      .fall_o  (pin_fall)
   );

   logic int_src, presc_en, presc_clr, tick;
   assign int_src   = (mode_q == MODE_TMR) || (mode_q == MODE_PW);
   assign presc_en  = run_q & int_src & ~pwr_down;
   assign presc_clr = ~(run_q & int_src);

   tmr_prescaler #(.DIV(PRESC_DIV)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (presc_clr),
      .en_i    (presc_en),
      .tick_o  (tick)
   );

   logic active_lvl, pulse_end, inc;
   assign active_lvl = edge_q ? ~pin_lvl : pin_lvl;
   assign pulse_end  = edge_q ? pin_rise : pin_fall;

   always_comb begin
      inc = 1'b0;
      unique case (mode_q)
         MODE_EVT: inc = run_q & (edge_q ? pin_fall : pin_rise);
         MODE_TMR: inc = tick;
         MODE_PW:  inc = tick & active_lvl;
         default:  inc = 1'b0;
      endcase
   end

   logic [CNT_W-1:0] cnt;
   logic             ovf;

   tmr_count_core #(.W(CNT_W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (wr_pre & ~run_q),
      .load_val_i   (reg_wdata[CNT_W-1:0]),
      .inc_i        (inc),
      .reload_val_i (pre_q),
      .cnt_o        (cnt),
      .ovf_o        (ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
         run_q  <= 1'b0;
         edge_q <= 1'b0;
      end else if (wr_ctrl) begin
         mode_q <= tmr_mode_e'(reg_wdata[MODE_HI:MODE_LO]);
         run_q  <= reg_wdata[RUN_BIT];
         edge_q <= reg_wdata[EDGE_BIT];
      end else if (run_q && mode_q == MODE_PW && pulse_end) begin
         run_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_q <= '0;
      else if (wr_pre) pre_q <= reg_wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         ien_q  <= 1'b0;
      end else begin
         if (ovf)                                flag_q <= 1'b1;
         else if (wr_stat && !reg_wdata[FLAG_BIT]) flag_q <= 1'b0;
         if (wr_stat) ien_q <= reg_wdata[IEN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_q <= 1'b0;
      else        wake_q <= pwr_down & (wake_q | (ovf & (mode_q == MODE_EVT)));
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_CTRL: begin
            reg_rdata[MODE_HI:MODE_LO] = mode_q;
            reg_rdata[RUN_BIT]         = run_q;
            reg_rdata[EDGE_BIT]        = edge_q;
         end
         ADDR_CNT:  reg_rdata[CNT_W-1:0] = cnt;
         ADDR_STAT: begin
            reg_rdata[FLAG_BIT] = flag_q;
            reg_rdata[IEN_BIT]  = ien_q;
         end
         default:   reg_rdata[CNT_W-1:0] = pre_q;
      endcase
   end

   assign irq  = flag_q & ien_q;
   assign wake = wake_q;

endmodule

// File: rtl/tmr_evt_cnt_chk.sv
module tmr_evt_cnt_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              pwr_down,
   input logic              irq,
   input logic              wake,
   input tmr_mode_e         mode,
   input logic              run,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  pre,
   input logic              ien
);

   logic wr_pre, wr_ctrl, wr_stat;
   assign wr_pre  = reg_wr && (reg_addr == ADDR_CNT);
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
   assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);

   assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((!run || mode == MODE_OFF) && !wr_pre) |=> $stable(cnt));

   assert_pd_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_down && mode != MODE_EVT && !wr_pre) |=> $stable(cnt));

   assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_TMR && run && !wr_pre && !wr_ctrl) |=>
         (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == pre));

   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_stat) |=> irq);

   assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ien);

   assert_wake_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_down |=> !wake);

   assert_run_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run) && !$past(wr_ctrl)) |-> $past(mode) == MODE_PW);

endmodule

bind tmr_evt_cnt tmr_evt_cnt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .pwr_down (pwr_down),
   .irq      (irq),
   .wake     (wake),
   .mode     (mode_q),
   .run      (run_q),
   .cnt      (cnt),
   .pre      (pre_q),
   .ien      (ien_q)
);

// File: tb/tmr_evt_cnt_tb.sv
module tmr_evt_cnt_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       tmr_pin = 1'b0;
   logic       pwr_down = 1'b0;
   logic       irq, wake;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   tmr_evt_cnt u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .tmr_pin   (tmr_pin),
      .pwr_down  (pwr_down),
      .irq       (irq),
      .wake      (wake)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int a = 0; a < 4; a++) begin
         rd_reg(2'(a), d);
         check("R1 reset register", d, 8'h00);
      end
      check("R1 reset irq", {7'b0, irq}, 8'h00);
      check("R1 reset wake", {7'b0, wake}, 8'h00);
   endtask

   task automatic t_preload();
      logic [7:0] d;
      wr_reg(2'd1, 8'h10);
      rd_reg(2'd1, d); check("R3 load while stopped", d, 8'h10);
      wr_reg(2'd0, 8'h10);            // mode 00, run 1
      wr_reg(2'd1, 8'h40);
      rd_reg(2'd1, d); check("R3 count kept while running", d, 8'h10);
      rd_reg(2'd3, d); check("R2 preload readback", d, 8'h40);
      rd_reg(2'd0, d); check("R2 control readback", d, 8'h10);
      wait_n(12);
      rd_reg(2'd1, d); check("R5 mode 00 holds", d, 8'h10);
   endtask

   task automatic t_timer();
      logic [7:0] d, held;
      wr_reg(2'd0, 8'h90);
      wait_n(3);
      rd_reg(2'd1, d); check("R4 before 4th edge", d, 8'h10);
      wait_n(1);
      rd_reg(2'd1, d); check("R4 first step", d, 8'h11);
      wait_n(8);
      rd_reg(2'd1, d); check("R4 later steps", d, 8'h13);
      wr_reg(2'd0, 8'h80);
      rd_reg(2'd1, held);
      wait_n(12);
      rd_reg(2'd1, d); check("R5 run 0 holds", d, held);
   endtask

   task automatic t_overflow();
      logic [7:0] d;
      wr_reg(2'd1, 8'hFE);
      wr_reg(2'd2, 8'h00);
      wr_reg(2'd0, 8'h90);
      wait_n(4);
      rd_reg(2'd1, d); check("R6 reach max", d, 8'hFF);
      wait_n(4);
      rd_reg(2'd1, d); check("R6 reload", d, 8'hFE);
      rd_reg(2'd2, d); check("R6 flag set", d, 8'h01);
      check("R7 irq masked", {7'b0, irq}, 8'h00);
      wr_reg(2'd0, 8'h00);
      wr_reg(2'd2, 8'h03);
      rd_reg(2'd2, d); check("R7 write 1 keeps flag", d, 8'h03);
      check("R7 irq enabled", {7'b0, irq}, 8'h01);
      wr_reg(2'd2, 8'h02);
      rd_reg(2'd2, d); check("R7 write 0 clears flag", d, 8'h02);
      check("R7 irq cleared", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_event();
      logic [7:0] d;
      wr_reg(2'd1, 8'h00);
      wr_reg(2'd0, 8'h50);
      tmr_pin = 1'b1; wait_n(4);
      rd_reg(2'd1, d); check("R8 rising counted", d, 8'h01);
      tmr_pin = 1'b0; wait_n(4);
      rd_reg(2'd1, d); check("R8 falling ignored", d, 8'h01);
      wr_reg(2'd0, 8'h58);
      tmr_pin = 1'b1; wait_n(4);
      rd_reg(2'd1, d); check("R8 rising ignored", d, 8'h01);
      tmr_pin = 1'b0; wait_n(4);
      rd_reg(2'd1, d); check("R8 falling counted", d, 8'h02);
      wr_reg(2'd0, 8'h00);
   endtask

   task automatic t_pulse();
      logic [7:0] d;
      wr_reg(2'd1, 8'h20);
      wr_reg(2'd0, 8'hD0);
      wait_n(8);
      rd_reg(2'd1, d); check("R9 idle level no count", d, 8'h20);
      tmr_pin = 1'b1; wait_n(40);
      tmr_pin = 1'b0; wait_n(6);
      rd_reg(2'd1, d); check("R9 pulse length", d, 8'h2A);
      rd_reg(2'd0, d); check("R9 run cleared", d, 8'hC0);
      wr_reg(2'd0, 8'h00);
   endtask

   task automatic t_powerdown();
      logic [7:0] d;
      wr_reg(2'd2, 8'h02);
      wr_reg(2'd1, 8'hFE);
      pwr_down = 1'b1;
      wr_reg(2'd0, 8'h50);
      tmr_pin = 1'b1; wait_n(4);
      rd_reg(2'd1, d); check("R10 event counts in power-down", d, 8'hFF);
      check("R11 no wake before overflow", {7'b0, wake}, 8'h00);
      tmr_pin = 1'b0; wait_n(4);
      tmr_pin = 1'b1; wait_n(4);
      rd_reg(2'd1, d); check("R10 event overflow reload", d, 8'hFE);
      check("R11 wake set", {7'b0, wake}, 8'h01);
      check("R11 irq with wake", {7'b0, irq}, 8'h01);
      wait_n(5);
      check("R11 wake held", {7'b0, wake}, 8'h01);
      pwr_down = 1'b0; wait_n(1);
      check("R11 wake released", {7'b0, wake}, 8'h00);
      wr_reg(2'd0, 8'h00);
      wr_reg(2'd2, 8'h02);
      wr_reg(2'd1, 8'h05);
      pwr_down = 1'b1;
      wr_reg(2'd0, 8'h90);
      wait_n(20);
      rd_reg(2'd1, d); check("R10 timer frozen", d, 8'h05);
      check("R11 no wake in timer mode", {7'b0, wake}, 8'h00);
      pwr_down = 1'b0; wait_n(4);
      rd_reg(2'd1, d); check("R10 timer resumes", d, 8'h06);
      wr_reg(2'd0, 8'h00);
   endtask

   task automatic t_collide();
      logic [7:0] d;
      tmr_pin = 1'b0;
      wr_reg(2'd1, 8'hFF);
      wr_reg(2'd2, 8'h02);
      wr_reg(2'd0, 8'h50);
      wait_n(4);
      tmr_pin = 1'b1;
      wait_n(2);
      reg_addr = 2'd2; reg_wdata = 8'h02; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      rd_reg(2'd2, d); check("R12 set wins over clear", d, 8'h03);
      rd_reg(2'd1, d); check("R12 reload on same edge", d, 8'hFF);
      wr_reg(2'd2, 8'h02);
      rd_reg(2'd2, d); check("R12 lone clear afterwards", d, 8'h02);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_preload();
      t_timer();
      t_overflow();
      t_event();
      t_pulse();
      t_powerdown();
      t_collide();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule